// File: doc/BRIEF.md
# Sample-Rate Normalizing Clock Divider

This block derives a synchronisation clock for a switch-mode power supply from the audio frame clock, which runs at whatever sample rate the current material uses. The power supply locks its PWM switching to this clock. A 2-bit select input sets a divide ratio of 1, 2 or 4, so that material at single, double or quadruple rate always gives a sync clock at one of the two base rates, 44.1 kHz or 48 kHz. A fourth select code turns the sync clock off. With no sync clock, the supply runs on its own oscillator.

The select bits come from general-purpose outputs of the system controller and are synchronous to the system clock. The frame clock is asynchronous. It passes through a flop-chain synchroniser, and the logic acts on its rising and falling edges in the system clock domain. When the select code changes, the output is held low for a programmable number of frame-clock periods. This lets the supply free-run while the rate settles. The divider then restarts at the start of a high phase. Reset is synchronous and active low.

Top module: `srate_sync_div`

## Requirements
- R1: With select code 2'b00, the output goes high after each rising edge of the frame clock and goes low after each falling edge. The frame clock is passed through undivided.
- R2: With select code 2'b01, the output divides the frame clock by two. It is high for one full frame period and low for the next. The high phase starts on the first rising edge after a hold.
- R3: With select code 2'b10, the output divides the frame clock by four. It is high for two frame periods and low for two. The high phase starts on the first rising edge after a hold.
- R4: With select code 2'b11, the output stays low.
- R5: A change of the select code drives the output low within two system clocks. The output then stays low for HOLD_EDGES rising edges of the frame clock (default 4). The next rising edge is the first edge of the new pattern.
- R6: The output rises only as a result of a synchronised rising edge of the frame clock. With the default two synchroniser stages, the output changes on the third system clock edge after the frame clock changes.
- R7: While reset is low at a clock edge, the output goes low and the divider count clears. After reset the hold of R5 applies before the output first rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_clk_i | input | 1 | Audio frame clock at the current sample rate, asynchronous |
| fsel_i | input | 2 | Ratio select: 00 divide by 1, 01 divide by 2, 10 divide by 4, 11 off |
| sync_o | output | 1 | Normalised sync clock for the power supply |

## Verification
The assertions check on every cycle that the output is low whenever a hold is running, and that it goes low two clocks after any select change. They also check that it stays low under the off code, rises only after a detected rising edge, and clears under reset. The exact waveform in each divide mode can only be shown by the bench scenarios. This covers the 50% duty in frame periods, the phase of the first high after a hold, the length of the hold in frame edges and the latency through the synchroniser. The bench compares the output against an edge-level model over random mode sequences.

// File: rtl/srn_pkg.sv
package srn_pkg;

   // Ratio select codes; the code value equals log2 of the divide ratio.
   typedef enum logic [1:0] {
      SEL_DIV1 = 2'b00,
      SEL_DIV2 = 2'b01,
      SEL_DIV4 = 2'b10,
      SEL_OFF  = 2'b11
   } srn_sel_e;

   localparam int unsigned SRN_MAX_SHIFT = 2;
   localparam int unsigned SRN_CNT_W     = SRN_MAX_SHIFT;

   // Index of the last count in a divide cycle for a given code.
   function automatic logic [SRN_CNT_W-1:0] srn_last(input srn_sel_e s);
      case (s)
         SEL_DIV2: srn_last = SRN_CNT_W'(1);
         SEL_DIV4: srn_last = SRN_CNT_W'(3);
         default:  srn_last = '0;
      endcase
   endfunction

   // Count at which the output drops (half the ratio).
   function automatic logic [SRN_CNT_W-1:0] srn_half(input srn_sel_e s);
      case (s)
         SEL_DIV2: srn_half = SRN_CNT_W'(1);
         SEL_DIV4: srn_half = SRN_CNT_W'(2);
         default:  srn_half = '0;
      endcase
   endfunction

endpackage

// File: rtl/srn_edge_sync.sv
module srn_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o,
   output logic fall_o
);

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("srn_edge_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < int'(STAGES); i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[i] <= 1'b0;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain_q[STAGES-1];
   end

   assign rise_o =  chain_q[STAGES-1] & ~last_q;
   assign fall_o = ~chain_q[STAGES-1] &  last_q;

endmodule

// File: rtl/srn_sel_guard.sv
module srn_sel_guard
   import srn_pkg::*;
#(
   parameter int unsigned HOLD_EDGES = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] sel_i,
   input  logic       rise_i,
   output srn_sel_e   sel_o,
   output logic       run_o
);

   localparam int unsigned HOLD_W = $clog2(HOLD_EDGES + 1);
   localparam logic [HOLD_W-1:0] HOLD_INIT = HOLD_W'(HOLD_EDGES);

   generate
      if (HOLD_EDGES < 1) begin : g_bad_hold
         $error("srn_sel_guard: HOLD_EDGES must be at least 1");
      end
   endgenerate

   srn_sel_e          sel_q;
   logic [HOLD_W-1:0] hold_q;
   logic              sel_change;

   assign sel_change = (srn_sel_e'(sel_i) != sel_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q  <= SEL_DIV1;
         hold_q <= HOLD_INIT;
      end else begin
         sel_q <= srn_sel_e'(sel_i);
         if (sel_change)
            hold_q <= HOLD_INIT;
         else if (rise_i && (hold_q != '0))
            hold_q <= hold_q - HOLD_W'(1);
      end
   end

   assign sel_o = sel_q;
   assign run_o = (hold_q == '0);

endmodule

// File: rtl/srn_ratio_div.sv
module srn_ratio_div
   import srn_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  srn_sel_e sel_i,
   input  logic     run_i,
   input  logic     rise_i,
   input  logic     fall_i,
   output logic     out_o
);

   logic [SRN_CNT_W-1:0] cnt_q;
   logic [SRN_CNT_W-1:0] cnt_last;
   logic [SRN_CNT_W-1:0] cnt_half;

   assign cnt_last = srn_last(sel_i);
   assign cnt_half = srn_half(sel_i);

   always_ff @(posedge clk) begin
      if (!rst_n || !run_i || (sel_i == SEL_OFF)) begin
         out_o <= 1'b0;
         cnt_q <= '0;
      end else if (sel_i == SEL_DIV1) begin
         cnt_q <= '0;
         if (rise_i)      out_o <= 1'b1;
         else if (fall_i) out_o <= 1'b0;
      end else if (rise_i) begin
         if (cnt_q == '0)            out_o <= 1'b1;
         else if (cnt_q == cnt_half) out_o <= 1'b0;
         cnt_q <= (cnt_q == cnt_last) ? '0 : cnt_q + SRN_CNT_W'(1);
      end
   end

endmodule

// File: rtl/srate_sync_div.sv
module srate_sync_div
   import srn_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HOLD_EDGES  = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_clk_i,
   input  logic [1:0] fsel_i,
   output logic       sync_o
);

   logic     edge_rise;
   logic     edge_fall;
   logic     hold_done;
   srn_sel_e sel_cur;

   srn_edge_sync #(.STAGES(SYNC_STAGES)) i_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i(frame_clk_i),
      .rise_o (edge_rise),
      .fall_o (edge_fall)
   );

   srn_sel_guard #(.HOLD_EDGES(HOLD_EDGES)) i_guard (
      .clk   (clk),
      .rst_n (rst_n),
      .sel_i (fsel_i),
      .rise_i(edge_rise),
      .sel_o (sel_cur),
      .run_o (hold_done)
   );

   srn_ratio_div i_div (
      .clk   (clk),
      .rst_n (rst_n),
      .sel_i (sel_cur),
      .run_i (hold_done),
      .rise_i(edge_rise),
      .fall_i(edge_fall),
      .out_o (sync_o)
   );

endmodule

// File: rtl/srn_sync_div_chk.sv
module srn_sync_div_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] fsel_i,
   input logic       sync_o,
   input logic       edge_rise,
   input logic       run
);

   // R4: a held off code keeps the output low
   p_off_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fsel_i == 2'b11 && $past(fsel_i) == 2'b11) |=> !sync_o);

   // R5: any select change mutes the output within two clocks
   p_change_mute_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fsel_i != $past(fsel_i)) |=> ##1 !sync_o);

   // R5: no output while the hold is still counting
   p_hold_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !sync_o);

   // R6: the output rises only after a detected frame-clock rising edge
   p_rise_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_o) |-> $past(edge_rise));

   // R7: reset clears the output
   p_reset_low_r7: assert property (@(posedge clk)
      !rst_n |=> !sync_o);

endmodule

bind srate_sync_div srn_sync_div_chk i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .fsel_i   (fsel_i),
   .sync_o   (sync_o),
   .edge_rise(edge_rise),
   .run      (hold_done)
);

// File: tb/test_srate_sync_div.sv
`timescale 1ns/1ps
module test_srate_sync_div;

   localparam int HOLD = 4;
   localparam int HP   = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_clk_i = 1'b0;
   logic [1:0] fsel_i = 2'b00;
   logic       sync_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int m_sel, m_hold, m_cnt;
   bit m_out;

   always #2.5 clk = ~clk;

   srate_sync_div #(.SYNC_STAGES(2), .HOLD_EDGES(HOLD)) i_srate_sync_div (
      .clk(clk), .rst_n(rst_n), .frame_clk_i(frame_clk_i),
      .fsel_i(fsel_i), .sync_o(sync_o)
   );

   function automatic string req_of(int sel, int hold);
      if (hold > 0) return "R5";
      case (sel)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         default: return "R4";
      endcase
   endfunction

   function automatic int ratio_of(int sel);
      return (sel == 1) ? 2 : 4;
   endfunction

   task automatic check(input string req, input bit act, input bit exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s sync_o=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   // model one frame-clock edge
   task automatic model_edge(input bit level);
      if (level) begin
         if (m_hold > 0) begin
            m_hold--; m_out = 0;
         end else if (m_sel == 0) m_out = 1;
         else if (m_sel == 3) m_out = 0;
         else begin
            if (m_cnt == 0) m_out = 1;
            else if (m_cnt == ratio_of(m_sel) / 2) m_out = 0;
            m_cnt = (m_cnt + 1) % ratio_of(m_sel);
         end
      end else if (m_hold == 0 && m_sel == 0) m_out = 0;
   endtask

   task automatic half(input bit level);
      string r;
      @(negedge clk);
      frame_clk_i = level;
      r = req_of(m_sel, m_hold);
      model_edge(level);
      repeat (HP) @(posedge clk);
      #1 check(r, sync_o, m_out);
   endtask

   task automatic period();
      half(1'b1);
      half(1'b0);
   endtask

   task automatic set_sel(input int v);
      @(negedge clk);
      fsel_i = v[1:0];
      if (v != m_sel) begin
         m_sel = v; m_hold = HOLD; m_cnt = 0; m_out = 0;
      end
      repeat (3) @(posedge clk);
      #1 check("R5", sync_o, m_out);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 check("R7", sync_o, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      m_sel = fsel_i; m_hold = HOLD; m_cnt = 0; m_out = 0;
      repeat (2) @(posedge clk);
      #1 check("R7", sync_o, 1'b0);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'd20240611);
      m_sel = 0; m_hold = HOLD; m_cnt = 0; m_out = 0;
      repeat (4) @(posedge clk);
      #1 check("R7", sync_o, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      // R7: hold after reset, then pass-through (R1)
      for (int i = 0; i < HOLD + 3; i++) period();

      // R6: latency through the synchroniser in pass-through mode
      @(negedge clk);
      frame_clk_i = 1'b1;
      repeat (2) @(posedge clk);
      #1 check("R6", sync_o, 1'b0);
      @(posedge clk);
      #1 check("R6", sync_o, 1'b1);
      model_edge(1'b1);
      repeat (HP) @(posedge clk);
      half(1'b0);

      // directed: divide by 2 (R2), by 4 (R3), off (R4)
      set_sel(1);
      for (int i = 0; i < HOLD + 6; i++) period();
      set_sel(2);
      for (int i = 0; i < HOLD + 9; i++) period();
      set_sel(3);
      for (int i = 0; i < HOLD + 5; i++) period();

      // R5: change during a hold restarts it
      set_sel(2);
      period(); period();
      set_sel(1);
      for (int i = 0; i < HOLD + 4; i++) period();

      // R7: reset in the middle of divide-by-4 output
      set_sel(2);
      for (int i = 0; i < HOLD + 1; i++) period();
      do_reset();
      for (int i = 0; i < HOLD + 4; i++) period();

      // random mode sequences
      for (int k = 0; k < 40; k++) begin
         set_sel($urandom_range(0, 3));
         for (int i = 0; i < int'($urandom_range(2, 14)); i++) period();
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule